// File: doc/BRIEF.md
# Indexed Configuration Register File

This block holds the configuration bytes of a memory controller behind an 8-bit I/O bus. Most registers are reached through an index/data pair: software first writes a register number to the index port (22h), then makes exactly one access, read or write, to the data port (23h). The index is single-use. Each data-port access consumes it, so a second access needs a second index write, even when it goes to the same register. Eight more registers sit at I/O addresses E0h to E7h and are read and written directly, with no index step.

Each register has its own reset value. It has a mask of reserved bits, which always read zero. Some registers also have read-only fields. All registers are driven out on one flat bus for the logic they control. Only the I/O address compare is decoded here. The meaning of each field belongs to the blocks that use the bus.

Top module: `cfg_regfile`

## Requirements
- R1: A write to port 22h arms the index. The next data-port access (23h) with an armed index from B4h to C6h reaches register slot (index − B4h), so the nineteen indexed registers take slots 0 to 18 in index order.
- R2: Every data-port access clears the armed index. A data-port access with no armed index leaves all registers unchanged, and a read of it returns FFh.
- R3: Addresses E0h to E7h reach slots 19 to 26 directly, with no index write. A direct access neither arms nor clears a pending index.
- R4: A data-port access whose armed index is outside B4h to C6h returns FFh on a read and changes nothing on a write. It still clears the index.
- R5: Reserved bits read 0 whatever value is written. They are: bit 7 of B4h, bits 3:0 of B5h, all of B8h, bit 0 of BAh, bits 1:0 of BBh, and bits 3 and 7 of BDh and BEh.
- R6: While the active-high synchronous reset `rst` is high, every register takes its reset value. B4h is 1Fh, B5h is 30h, B9h is 02h, BAh is E8h and BBh is 4Ch. All other registers, including E0h to E7h, reset to 00h.
- R7: Bits 6:5 of B4h are read-only. They always read the `VERSION` parameter (default 00), and writes do not change them.
- R8: In BAh, a write that puts 11 in bits 2:1 leaves that field at its previous value. The other bits of the same write still take effect.
- R9: `cfg_bus[8k+7:8k]` carries slot k. A write appears on the bus in the cycle after the clock edge that accepts it.
- R10: `io_rdata` is combinational. It is 00h in any cycle without `io_rd`. When `io_rd` is high it carries the selected register, or FFh when nothing is selected. Reads of port 22h and of addresses outside the block select nothing. Those reads, and writes to addresses outside the block, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W (16) | I/O address, compared in full |
| io_rd | input | 1 | One-cycle read strobe |
| io_wr | input | 1 | One-cycle write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the `io_rd` cycle |
| cfg_bus | output | 216 | All 27 registers, slot k at bits 8k+7:8k |

## Verification
The assertions assume that `io_rd` and `io_wr` are never high in the same cycle. They also assume each strobe lasts one accepted edge per access. On that basis, a direct access between an index write and a data access cannot be mistaken for an index write. The bench drives each access for exactly one cycle with a single strobe, including in its pseudo-random phase. The mix it generates includes index writes to values both inside and outside the indexed range, stray data accesses, direct accesses and unrelated addresses. These keep the stimulus within that assumption while still reaching every ordering of index and data accesses.

// File: rtl/cfg_pkg.sv
`timescale 1ns/1ps
package cfg_pkg;
    localparam int DW        = 8;
    localparam int N_IDX     = 19;
    localparam int N_DIR     = 8;
    localparam int N_REG     = N_IDX + N_DIR;
    localparam int SLOT_W    = $clog2(N_REG);
    localparam int BUS_W     = N_REG * DW;
    localparam logic [7:0] INDEX_PORT = 8'h22;
    localparam logic [7:0] DATA_PORT  = 8'h23;
    localparam logic [7:0] IDX_FIRST  = 8'hB4;
    localparam logic [7:0] IDX_LAST   = IDX_FIRST + 8'(N_IDX - 1);
    localparam logic [7:0] DIR_BASE   = 8'hE0;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_INDEX,
        ACC_DATA,
        ACC_DIRECT
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e   kind;
        logic        wr;
        logic [2:0]  dslot;
        logic [7:0]  wdata;
    } acc_t;

    // reset value of the writable bits of a slot
    function automatic logic [7:0] reg_default(input int s);
        case (s)
            0:       return 8'h1F;
            1:       return 8'h30;
            5:       return 8'h02;
            6:       return 8'hE8;
            7:       return 8'h4C;
            default: return 8'h00;
        endcase
    endfunction

    // bits that accept written data; all others read zero unless read-only
    function automatic logic [7:0] reg_wmask(input int s);
        case (s)
            0:       return 8'h1F;
            1:       return 8'hF0;
            4:       return 8'h00;
            6:       return 8'hFE;
            7:       return 8'hFC;
            9, 10:   return 8'h77;
            default: return 8'hFF;
        endcase
    endfunction

    // field whose all-ones code is illegal: such a write keeps the old field
    function automatic logic [7:0] reg_guard(input int s);
        return (s == 6) ? 8'h06 : 8'h00;
    endfunction

    // read-only bits
    function automatic logic [7:0] reg_romask(input int s);
        return (s == 0) ? 8'h60 : 8'h00;
    endfunction
endpackage

// File: rtl/cfg_port_decode.sv
`timescale 1ns/1ps
module cfg_port_decode
    import cfg_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [7:0]        wdata,
    output acc_t              acc
);
    localparam logic [ADDR_W-1:0] P_INDEX = ADDR_W'(INDEX_PORT);
    localparam logic [ADDR_W-1:0] P_DATA  = ADDR_W'(DATA_PORT);
    localparam logic [ADDR_W-1:0] P_DIR   = ADDR_W'(DIR_BASE);

    always_comb begin
        acc.wr    = wr;
        acc.dslot = addr[2:0];
        acc.wdata = wdata;
        acc.kind  = ACC_NONE;
        if (rd || wr) begin
            if (addr == P_INDEX)
                acc.kind = wr ? ACC_INDEX : ACC_NONE;
            else if (addr == P_DATA)
                acc.kind = ACC_DATA;
            else if (addr[ADDR_W-1:3] == P_DIR[ADDR_W-1:3])
                acc.kind = ACC_DIRECT;
        end
    end
endmodule

// File: rtl/cfg_index_tracker.sv
`timescale 1ns/1ps
module cfg_index_tracker
    import cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  acc_t              acc,
    output logic              pend,
    output logic              hit,
    output logic              we,
    output logic [SLOT_W-1:0] slot
);
    logic [7:0] idx_q;
    logic       idx_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= 1'b0;
            idx_q <= 8'h00;
        end else if (acc.kind == ACC_INDEX) begin
            pend  <= 1'b1;
            idx_q <= acc.wdata;
        end else if (acc.kind == ACC_DATA) begin
            pend  <= 1'b0;
        end
    end

    assign idx_ok = (idx_q >= IDX_FIRST) && (idx_q <= IDX_LAST);

    always_comb begin
        hit  = 1'b0;
        slot = '0;
        case (acc.kind)
            ACC_DATA: begin
                hit  = pend && idx_ok;
                slot = SLOT_W'(idx_q - IDX_FIRST);
            end
            ACC_DIRECT: begin
                hit  = 1'b1;
                slot = SLOT_W'(N_IDX) + SLOT_W'(acc.dslot);
            end
            default: ;
        endcase
    end

    assign we = hit && acc.wr;
endmodule

// File: rtl/cfg_reg_cell.sv
`timescale 1ns/1ps
module cfg_reg_cell #(
    parameter logic [7:0] DEF    = 8'h00,
    parameter logic [7:0] WMASK  = 8'hFF,
    parameter logic [7:0] GUARD  = 8'h00,
    parameter logic [7:0] ROMASK = 8'h00,
    parameter logic [7:0] ROVAL  = 8'h00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [7:0] wdata,
    output logic [7:0] value
);
    logic [7:0] q;
    logic [7:0] nxt;

    always_comb begin
        nxt = wdata & WMASK;
        if ((GUARD != 8'h00) && ((wdata & GUARD) == GUARD))
            nxt = (nxt & ~GUARD) | (q & GUARD);
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= DEF & WMASK;
        else if (we)
            q <= nxt;
    end

    assign value = q | (ROVAL & ROMASK);
endmodule

// File: rtl/cfg_reg_bank.sv
`timescale 1ns/1ps
module cfg_reg_bank
    import cfg_pkg::*;
#(
    parameter logic [1:0] VERSION = 2'b00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SLOT_W-1:0] slot,
    input  logic [7:0]        wdata,
    output logic [BUS_W-1:0]  cfg_bus,
    output logic [7:0]        rd_val
);
    localparam int N_SLOT = 2 ** SLOT_W;

    logic [7:0] vals [N_SLOT];

    for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
        if (g < N_REG) begin : g_reg
            localparam logic [7:0] P_ROVAL = (g == 0) ? {1'b0, VERSION, 5'b0} : 8'h00;
            cfg_reg_cell #(
                .DEF   (reg_default(g)),
                .WMASK (reg_wmask(g)),
                .GUARD (reg_guard(g)),
                .ROMASK(reg_romask(g)),
                .ROVAL (P_ROVAL)
            ) u_cell (
                .clk  (clk),
                .rst  (rst),
                .we   (we && (slot == SLOT_W'(g))),
                .wdata(wdata),
                .value(vals[g])
            );
            assign cfg_bus[g*DW +: DW] = vals[g];
        end else begin : g_pad
            assign vals[g] = 8'hFF;
        end
    end

    assign rd_val = vals[slot];
endmodule

// File: rtl/cfg_regfile.sv
`timescale 1ns/1ps
module cfg_regfile
    import cfg_pkg::*;
#(
    parameter int         ADDR_W  = 16,
    parameter logic [1:0] VERSION = 2'b00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic [BUS_W-1:0]  cfg_bus
);
    acc_t              acc;
    logic              idx_pend;
    logic              sel_hit;
    logic              sel_we;
    logic [SLOT_W-1:0] sel_slot;
    logic [7:0]        sel_val;

    cfg_port_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (io_addr),
        .rd   (io_rd),
        .wr   (io_wr),
        .wdata(io_wdata),
        .acc  (acc)
    );

    cfg_index_tracker u_track (
        .clk (clk),
        .rst (rst),
        .acc (acc),
        .pend(idx_pend),
        .hit (sel_hit),
        .we  (sel_we),
        .slot(sel_slot)
    );

    cfg_reg_bank #(.VERSION(VERSION)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .we     (sel_we),
        .slot   (sel_slot),
        .wdata  (io_wdata),
        .cfg_bus(cfg_bus),
        .rd_val (sel_val)
    );

    assign io_rdata = !io_rd ? 8'h00 : (sel_hit ? sel_val : 8'hFF);
endmodule

// File: rtl/cfg_regfile_chk.sv
`timescale 1ns/1ps
module cfg_regfile_chk
    import cfg_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_rd,
    input logic              io_wr,
    input logic [7:0]        io_rdata,
    input logic [BUS_W-1:0]  cfg_bus,
    input logic              idx_pend
);
    localparam logic [ADDR_W-1:0] C_IDX  = ADDR_W'(INDEX_PORT);
    localparam logic [ADDR_W-1:0] C_DATA = ADDR_W'(DATA_PORT);
    localparam logic [ADDR_W-1:0] C_DIR  = ADDR_W'(DIR_BASE);

    function automatic logic [BUS_W-1:0] reset_image();
        logic [BUS_W-1:0] v = '0;
        for (int s = 0; s < N_REG; s++)
            v[s*DW +: DW] = reg_default(s) & reg_wmask(s);
        return v;
    endfunction

    wire data_acc   = (io_rd || io_wr) && (io_addr == C_DATA);
    wire direct_acc = (io_rd || io_wr) && (io_addr[ADDR_W-1:3] == C_DIR[ADDR_W-1:3]);

    a_r10_single_strobe: assert property (@(posedge clk) disable iff (rst)
        !(io_rd && io_wr));

    a_r1_index_arms: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == C_IDX) |=> idx_pend);

    a_r2_data_consumes: assert property (@(posedge clk) disable iff (rst)
        data_acc |=> !idx_pend);

    a_r2_stray_read_ff: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_addr == C_DATA && !idx_pend) |-> io_rdata == 8'hFF);

    a_r2_stray_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == C_DATA && !idx_pend) |=> $stable(cfg_bus));

    a_r3_direct_keeps_index: assert property (@(posedge clk) disable iff (rst)
        direct_acc |=> idx_pend == $past(idx_pend));

    a_r6_reset_defaults: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> cfg_bus == reset_image());

    a_r8_no_illegal_code: assert property (@(posedge clk) disable iff (rst)
        cfg_bus[6*DW+1 +: 2] != 2'b11);

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !io_rd |-> io_rdata == 8'h00);

    for (genvar s = 0; s < N_REG; s++) begin : g_rsv
        a_r5_reserved_zero: assert property (@(posedge clk) disable iff (rst)
            (cfg_bus[s*DW +: DW] & ~(reg_wmask(s) | reg_romask(s))) == 8'h00);
    end
endmodule

bind cfg_regfile cfg_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .io_addr (io_addr),
    .io_rd   (io_rd),
    .io_wr   (io_wr),
    .io_rdata(io_rdata),
    .cfg_bus (cfg_bus),
    .idx_pend(idx_pend)
);

// File: tb/cfg_regfile_bench.sv
`timescale 1ns/1ps
module cfg_regfile_bench;
    localparam int NR = 27;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [15:0]  io_addr = '0;
    logic         io_rd = 1'b0;
    logic         io_wr = 1'b0;
    logic [7:0]   io_wdata = '0;
    logic [7:0]   io_rdata;
    logic [NR*8-1:0] cfg_bus;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit run = 1'b0;
    string cur_tag = "R6 reset";

    // behavioural reference model
    logic [7:0] mreg [NR];
    bit         m_pend;
    logic [7:0] m_idx;

    cfg_regfile u_cfg_regfile (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_bus(cfg_bus)
    );

    always #2.5 clk = ~clk;

    // register address -> slot (indexed B4..C6, direct E0..E7), -1 if none
    function automatic int slot_of_idx(input logic [7:0] a);
        if (a >= 8'hB4 && a <= 8'hC6) return int'(a) - 'hB4;
        return -1;
    endfunction

    function automatic logic [7:0] m_default(input int s);
        case (s)
            0: return 8'h1F;   // R6 B4h
            1: return 8'h30;   // R6 B5h
            5: return 8'h02;   // R6 B9h
            6: return 8'hE8;   // R6 BAh
            7: return 8'h4C;   // R6 BBh
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] m_mask(input int s);
        case (s)
            0: return 8'h1F;          // R5 bit7 reserved, R7 6:5 read-only
            1: return 8'hF0;          // R5 B5h 3:0
            4: return 8'h00;          // R5 B8h
            6: return 8'hFE;          // R5 BAh bit0
            7: return 8'hFC;          // R5 BBh 1:0
            9, 10: return 8'h77;      // R5 BDh/BEh
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] m_view(input int s);
        return mreg[s];   // version field reads 00 (R7)
    endfunction

    task automatic m_reset();
        for (int s = 0; s < NR; s++) mreg[s] = m_default(s);
        m_pend = 0;
        m_idx = 8'h00;
    endtask

    task automatic m_write(input int s, input logic [7:0] d);
        logic [7:0] nv;
        nv = d & m_mask(s);
        if (s == 6 && d[2:1] == 2'b11) nv[2:1] = mreg[6][2:1];   // R8
        mreg[s] = nv;
    endtask

    function automatic logic [7:0] m_read(input logic [15:0] a);
        if (a == 16'h0023) begin
            if (m_pend && slot_of_idx(m_idx) >= 0) return m_view(slot_of_idx(m_idx));
            return 8'hFF;
        end
        if (a[15:3] == 13'(16'h00E0 >> 3)) return m_view(19 + int'(a[2:0]));
        return 8'hFF;
    endfunction

    task automatic m_update(input bit wr, input logic [15:0] a, input logic [7:0] d);
        if (a == 16'h0022) begin
            if (wr) begin m_pend = 1; m_idx = d; end
        end else if (a == 16'h0023) begin
            if (wr && m_pend && slot_of_idx(m_idx) >= 0) m_write(slot_of_idx(m_idx), d);
            m_pend = 0;
        end else if (a[15:3] == 13'(16'h00E0 >> 3)) begin
            if (wr) m_write(19 + int'(a[2:0]), d);
        end
    endtask

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    // whole-bus comparison on every clock (R9)
    always @(negedge clk) begin
        if (run && !rst) begin
            logic [NR*8-1:0] exp;
            for (int s = 0; s < NR; s++) exp[s*8 +: 8] = m_view(s);
            compared++;
            if (cfg_bus !== exp) begin
                mismatched++;
                $display("FAIL %s R9 bus: got %h expected %h", cur_tag, cfg_bus, exp);
            end
        end
    end

    task automatic access(input bit wr, input logic [15:0] a, input logic [7:0] d, input string tag);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = wr; io_rd = !wr;
        #1;
        if (!wr) check8(tag, io_rdata, m_read(a));
        @(posedge clk);
        #1;
        m_update(wr, a, d);
        io_rd = 0; io_wr = 0;
    endtask

    task automatic idx_wr(input logic [7:0] i, input logic [7:0] d, input string tag);
        access(1, 16'h0022, i, tag);
        access(1, 16'h0023, d, tag);
    endtask

    task automatic idx_rd(input logic [7:0] i, input string tag);
        access(1, 16'h0022, i, tag);
        access(0, 16'h0023, 8'h00, tag);
    endtask

    task automatic do_reset();
        @(posedge clk); #1 rst = 1;
        repeat (2) @(posedge clk);
        #1 m_reset(); rst = 0;
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                mismatched++;
                $display("FAIL watchdog expired");
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
                $finish;
            end
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        m_reset();
        repeat (3) @(posedge clk);
        #1 rst = 0; run = 1;

        cur_tag = "R10 idle";
        @(negedge clk); #1 check8("R10 idle rdata", io_rdata, 8'h00);

        cur_tag = "R6 defaults";
        for (int i = 'hB4; i <= 'hC6; i++) idx_rd(8'(i), "R1 R6 R7 indexed default");
        for (int i = 0; i < 8; i++) access(0, 16'h00E0 + 16'(i), 8'h00, "R3 R6 direct default");

        cur_tag = "R5 all ones";
        for (int i = 'hB4; i <= 'hC6; i++) idx_wr(8'(i), 8'hFF, "R5 write");
        for (int i = 'hB4; i <= 'hC6; i++) idx_rd(8'(i), "R5 R8 readback ones");

        cur_tag = "R8 guard";
        idx_wr(8'hBA, 8'h04, "R8 set field 10");
        idx_wr(8'hBA, 8'h17, "R8 write 11 keeps field");
        idx_rd(8'hBA, "R8 field kept, others written");

        cur_tag = "R1 pattern";
        for (int i = 'hB4; i <= 'hC6; i++) idx_wr(8'(i), 8'(i * 37) ^ 8'h5A, "R1 pattern write");
        for (int i = 'hC6; i >= 'hB4; i--) idx_rd(8'(i), "R1 pattern readback");

        cur_tag = "R3 direct";
        for (int i = 0; i < 8; i++) access(1, 16'h00E0 + 16'(i), 8'(i * 29 + 3), "R3 direct write");
        for (int i = 0; i < 8; i++) access(0, 16'h00E0 + 16'(i), 8'h00, "R3 direct readback");

        cur_tag = "R2 single use";
        idx_rd(8'hB6, "R2 first read");
        access(0, 16'h0023, 8'h00, "R2 second read FF");
        idx_wr(8'hB6, 8'h11, "R2 indexed write");
        access(1, 16'h0023, 8'h99, "R2 stray write ignored");
        idx_rd(8'hB6, "R2 value after stray write");

        cur_tag = "R3 interleave";
        access(1, 16'h0022, 8'hB7, "R3 arm");
        access(1, 16'h00E3, 8'hC3, "R3 direct while armed");
        access(0, 16'h00E5, 8'h00, "R3 direct read while armed");
        access(1, 16'h0023, 8'h7E, "R3 data still reaches B7h");
        idx_rd(8'hB7, "R3 B7h readback");

        cur_tag = "R4 out of range";
        idx_wr(8'h00, 8'h55, "R4 write idx 00");
        idx_rd(8'hB3, "R4 read idx B3 FF");
        idx_wr(8'hC7, 8'h55, "R4 write idx C7");
        idx_rd(8'hFF, "R4 read idx FF");
        access(0, 16'h0023, 8'h00, "R4 index consumed FF");

        cur_tag = "R10 other addresses";
        access(0, 16'h0022, 8'h00, "R10 read index port FF");
        access(1, 16'h0123, 8'h42, "R10 foreign write");
        access(0, 16'h01E0, 8'h00, "R10 foreign read FF");
        access(0, 16'h00E8, 8'h00, "R10 past direct range FF");

        cur_tag = "R7 version";
        idx_wr(8'hB4, 8'h60, "R7 write version bits");
        idx_rd(8'hB4, "R7 version reads 00");

        cur_tag = "R6 mid reset";
        do_reset();
        idx_rd(8'hBB, "R6 BBh after reset");
        access(0, 16'h0023, 8'h00, "R6 index cleared by reset");

        cur_tag = "R9 mixed";
        for (int n = 0; n < 400; n++) begin
            logic [15:0] a;
            logic [7:0]  d;
            int k;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            k = int'(lfsr[3:0]) % 12;
            if (k < 4)       a = 16'h0022;
            else if (k < 7)  a = 16'h0023;
            else if (k < 11) a = 16'h00E0 + 16'(lfsr[6:4]);
            else             a = 16'h0040;
            d = (a == 16'h0022) ? 8'h B0 + 8'(int'(lfsr[15:8]) % 24) : lfsr[15:8];
            access(lfsr[7] | (a == 16'h0022), a, d, "R9 mixed");
        end

        @(negedge clk);
        run = 0;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule